// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the combinational arithmetic and logic stage of a 32-bit integer datapath. A 4-bit operation code selects one of sixteen operations, grouped as bitwise logic, addition with or without carry, forward and reverse subtraction with or without borrow, and four compare/test forms. Operand 2 arrives already shifted, with the shifter's carry-out alongside it. The block returns the result, a strobe that says whether the result should be written to a register, the next N, Z, C and V flag values and a strobe that says whether the flags should be written.

The compare/test operations (test-AND, test-XOR, compare, compare-negative) compute the same value as AND, XOR, subtract and add. They never request a result write and always request a flag write. All other operations request a result write and request a flag write only when the caller asks for it. Logic operations take C from the shifter and leave V unchanged. Arithmetic operations take C and V from the adder.

Internally a decoder maps the operation code (held in an enumerated type) to a unit selection, an operand swap, an operand inversion and a carry-in source. An adder/subtractor and a bitwise unit then compute in parallel, and the top level merges their outputs and the flags. The block holds no state and has no state machine. Because it has no state there are no states or transitions to list.

Top module: `alu_flag_core`

## Requirements
- R1: Operation codes 0, 1, 12, 13, 14 and 15 give op1 AND op2, op1 XOR op2, op1 OR op2, op2, op1 AND NOT op2 and NOT op2 respectively.
- R2: Code 4 gives op1 + op2 and code 5 gives op1 + op2 + C_in. C is the carry out of bit 31.
- R3: Code 2 gives op1 − op2 and code 6 gives op1 − op2 − (1 − C_in). C is 1 exactly when no borrow occurs.
- R4: Code 3 gives op2 − op1 and code 7 gives op2 − op1 − (1 − C_in). C follows the same no-borrow rule.
- R5: Codes 8, 9, 10 and 11 compute AND, XOR, the code-2 subtraction and the code-4 addition. They hold the result-write strobe low and the flag-write strobe high.
- R6: For codes other than 8 to 11, the result-write strobe is high and the flag-write strobe equals the set-flags input.
- R7: N equals result bit 31. Z is 1 exactly when the result is zero.
- R8: For the arithmetic codes (2–7, 10, 11), V is 1 exactly when the signed result does not fit in 32 bits. For all other codes V equals the V input.
- R9: For the logic codes (0, 1, 8, 9, 12–15), C equals the shifter carry-out input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | Operand 1 |
| op_b | input | 32 | Operand 2, already shifted |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| cur_c | input | 1 | Current C flag |
| cur_v | input | 1 | Current V flag |
| set_flags | input | 1 | Caller requests a flag update |
| opcode | input | 4 | Operation select |
| result | output | 32 | Computed value |
| result_we | output | 1 | Result should be written back |
| nxt_n | output | 1 | Next N flag |
| nxt_z | output | 1 | Next Z flag |
| nxt_c | output | 1 | Next C flag |
| nxt_v | output | 1 | Next V flag |
| flags_we | output | 1 | Flags should be written |

## Verification
On every evaluation the assertions check the following:
- The compare/test codes suppress the result write and force the flag write.
- A set-flags request always yields a flag write.
- N and Z track the result.
- Logic codes keep V and forward the shifter carry.
- The pass-through code returns operand 2.

Only the bench's reference model can show the arithmetic itself: carry as no-borrow, the extra borrow of the carry-using subtractions, the operand order of the reverse forms, and the signed-overflow corner values.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO,
        CIN_ONE,
        CIN_FLAG
    } cin_sel_e;

    typedef enum logic [2:0] {
        LF_AND,
        LF_EOR,
        LF_ORR,
        LF_PASSB,
        LF_BIC,
        LF_NOTB
    } logic_fn_e;

    typedef struct packed {
        logic      is_arith;
        logic      is_cmp;
        logic      swap;
        logic      invert;
        cin_sel_e  cin_sel;
        logic_fn_e lfn;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_flag_pkg::*;
(
    input  logic [3:0] opcode,
    output alu_ctrl_t  ctrl
);

    alu_op_e op;
    assign op = alu_op_e'(opcode);

    always_comb begin
        ctrl = '{is_arith: 1'b0, is_cmp: 1'b0, swap: 1'b0, invert: 1'b0,
                 cin_sel: CIN_ZERO, lfn: LF_AND};
        unique case (op)
            OP_AND: ctrl.lfn = LF_AND;
            OP_EOR: ctrl.lfn = LF_EOR;
            OP_TST: begin ctrl.lfn = LF_AND; ctrl.is_cmp = 1'b1; end
            OP_TEQ: begin ctrl.lfn = LF_EOR; ctrl.is_cmp = 1'b1; end
            OP_ORR: ctrl.lfn = LF_ORR;
            OP_MOV: ctrl.lfn = LF_PASSB;
            OP_BIC: ctrl.lfn = LF_BIC;
            OP_MVN: ctrl.lfn = LF_NOTB;
            OP_ADD: ctrl.is_arith = 1'b1;
            OP_CMN: begin ctrl.is_arith = 1'b1; ctrl.is_cmp = 1'b1; end
            OP_ADC: begin ctrl.is_arith = 1'b1; ctrl.cin_sel = CIN_FLAG; end
            OP_SUB: begin
                ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_ONE;
            end
            OP_CMP: begin
                ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_ONE;
                ctrl.is_cmp = 1'b1;
            end
            OP_SBC: begin
                ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.cin_sel = CIN_FLAG;
            end
            OP_RSB: begin
                ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.swap = 1'b1;
                ctrl.cin_sel = CIN_ONE;
            end
            OP_RSC: begin
                ctrl.is_arith = 1'b1; ctrl.invert = 1'b1; ctrl.swap = 1'b1;
                ctrl.cin_sel = CIN_FLAG;
            end
            default: ctrl.lfn = LF_AND;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         swap,
    input  logic         invert,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y_raw;
    logic [W-1:0] y;
    logic [W:0]   total;

    assign x     = swap ? b : a;
    assign y_raw = swap ? a : b;
    assign y     = invert ? ~y_raw : y_raw;
    assign total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum   = total[W-1:0];
    assign cout  = total[W];
    assign ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (fn)
            LF_AND:   y = a & b;
            LF_EOR:   y = a ^ b;
            LF_ORR:   y = a | b;
            LF_PASSB: y = b;
            LF_BIC:   y = a & ~b;
            LF_NOTB:  y = ~b;
            default:  y = a & b;
        endcase
    end

endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         shift_carry,
    input  logic         cur_c,
    input  logic         cur_v,
    input  logic         set_flags,
    input  logic [3:0]   opcode,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic         nxt_n,
    output logic         nxt_z,
    output logic         nxt_c,
    output logic         nxt_v,
    output logic         flags_we
);

    alu_ctrl_t    ctrl;
    logic         cin;
    logic [W-1:0] arith_y;
    logic [W-1:0] logic_y;
    logic         arith_c;
    logic         arith_v;

    alu_op_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    always_comb begin
        unique case (ctrl.cin_sel)
            CIN_ZERO: cin = 1'b0;
            CIN_ONE:  cin = 1'b1;
            CIN_FLAG: cin = cur_c;
            default:  cin = 1'b0;
        endcase
    end

    alu_addsub #(.W(W)) u_add (
        .a      (op_a),
        .b      (op_b),
        .swap   (ctrl.swap),
        .invert (ctrl.invert),
        .cin    (cin),
        .sum    (arith_y),
        .cout   (arith_c),
        .ovf    (arith_v)
    );

    alu_bitwise #(.W(W)) u_bit (
        .a  (op_a),
        .b  (op_b),
        .fn (ctrl.lfn),
        .y  (logic_y)
    );

    always_comb begin
        result    = ctrl.is_arith ? arith_y : logic_y;
        result_we = ~ctrl.is_cmp;
        flags_we  = set_flags | ctrl.is_cmp;
        nxt_n     = result[W-1];
        nxt_z     = (result == '0);
        nxt_c     = ctrl.is_arith ? arith_c : shift_carry;
        nxt_v     = ctrl.is_arith ? arith_v : cur_v;
    end

endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         shift_carry,
    input logic         cur_v,
    input logic         set_flags,
    input logic [3:0]   opcode,
    input logic [W-1:0] result,
    input logic         result_we,
    input logic         nxt_n,
    input logic         nxt_z,
    input logic         nxt_c,
    input logic         nxt_v,
    input logic         flags_we
);

    logic logic_class;
    logic cmp_class;
    assign logic_class = (opcode[2:1] == 2'b00) || (opcode[3:2] == 2'b11);
    assign cmp_class   = (opcode[3:2] == 2'b10);

    always_comb begin
        AST_CMP_NO_WRITE: assert (!cmp_class || (!result_we && flags_we)); // R5
        AST_SET_FLAGS: assert (!set_flags || flags_we); // R6
        AST_N_SIGN: assert (nxt_n == result[W-1]); // R7
        AST_Z_ZERO: assert (nxt_z == (result == '0)); // R7
        AST_V_HELD: assert (!logic_class || (nxt_v == cur_v)); // R8
        AST_C_SHIFTER: assert (!logic_class || (nxt_c == shift_carry)); // R9
        AST_PASS_B: assert (opcode != 4'd13 || result == op_b); // R1
        AST_OPA_USED: assert (opcode != 4'd0 || result == (op_a & op_b)); // R1
    end

endmodule

bind alu_flag_core alu_flag_core_chk #(.W(W)) u_chk (
    .op_a        (op_a),
    .op_b        (op_b),
    .shift_carry (shift_carry),
    .cur_v       (cur_v),
    .set_flags   (set_flags),
    .opcode      (opcode),
    .result      (result),
    .result_we   (result_we),
    .nxt_n       (nxt_n),
    .nxt_z       (nxt_z),
    .nxt_c       (nxt_c),
    .nxt_v       (nxt_v),
    .flags_we    (flags_we)
);

// File: tb/alu_flag_core_tb.sv
module alu_flag_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        shift_carry = 1'b0, cur_c = 1'b0, cur_v = 1'b0, set_flags = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [31:0] result;
    logic        result_we, nxt_n, nxt_z, nxt_c, nxt_v, flags_we;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    alu_flag_core u_dut (
        .op_a(op_a), .op_b(op_b), .shift_carry(shift_carry), .cur_c(cur_c),
        .cur_v(cur_v), .set_flags(set_flags), .opcode(opcode),
        .result(result), .result_we(result_we), .nxt_n(nxt_n), .nxt_z(nxt_z),
        .nxt_c(nxt_c), .nxt_v(nxt_v), .flags_we(flags_we)
    );

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic ci, input logic vi, input logic sf,
                         output logic [31:0] r, output logic rwe, output logic fwe,
                         output logic n, output logic z, output logic c, output logic v);
        longint ua, ub, sa, sb, t, ts;
        longint bw;
        bit arith, is_add;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        bw = ci ? 0 : 1;
        arith = 1; is_add = 0; t = 0; ts = 0; r = '0;
        case (op)
            4'd0, 4'd8:  begin arith = 0; r = a & b; end
            4'd1, 4'd9:  begin arith = 0; r = a ^ b; end
            4'd12:       begin arith = 0; r = a | b; end
            4'd13:       begin arith = 0; r = b; end
            4'd14:       begin arith = 0; r = a & ~b; end
            4'd15:       begin arith = 0; r = ~b; end
            4'd4, 4'd11: begin is_add = 1; t = ua + ub; ts = sa + sb; end
            4'd5:        begin is_add = 1; t = ua + ub + (ci ? 1 : 0); ts = sa + sb + (ci ? 1 : 0); end
            4'd2, 4'd10: begin t = ua - ub; ts = sa - sb; end
            4'd3:        begin t = ub - ua; ts = sb - sa; end
            4'd6:        begin t = ua - ub - bw; ts = sa - sb - bw; end
            default:     begin t = ub - ua - bw; ts = sb - sa - bw; end
        endcase
        if (arith) begin
            r = t[31:0];
            c = is_add ? (t >= 64'sh1_0000_0000) : (t >= 0);
            v = (ts > 64'sh7FFF_FFFF) || (ts < -64'sh8000_0000);
        end else begin
            c = sc;
            v = vi;
        end
        rwe = !(op >= 4'd8 && op <= 4'd11);
        fwe = sf || !rwe;
        n = r[31];
        z = (r == 32'd0);
    endtask

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'd4, 4'd5:               return "R2";
            4'd2, 4'd6:               return "R3";
            4'd3, 4'd7:               return "R4";
            4'd8, 4'd9, 4'd10, 4'd11: return "R5";
            default:                  return "R1";
        endcase
    endfunction

    task automatic chk1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h",
                     tag, what, opcode, op_a, op_b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic ci, input logic vi, input logic sf);
        logic [31:0] r;
        logic rwe, fwe, n, z, c, v;
        bit logical;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; shift_carry = sc; cur_c = ci; cur_v = vi; set_flags = sf;
        model(op, a, b, sc, ci, vi, sf, r, rwe, fwe, n, z, c, v);
        logical = (op[2:1] == 2'b00) || (op[3:2] == 2'b11);
        @(posedge clk);
        #1;
        compared++;
        chk1(res_tag(op), "result", result, r);
        chk1((op >= 4'd8 && op <= 4'd11) ? "R5" : "R6", "result_we", 32'(result_we), 32'(rwe));
        chk1((op >= 4'd8 && op <= 4'd11) ? "R5" : "R6", "flags_we", 32'(flags_we), 32'(fwe));
        chk1("R7", "N", 32'(nxt_n), 32'(n));
        chk1("R7", "Z", 32'(nxt_z), 32'(z));
        chk1(logical ? "R9" : res_tag(op), "C", 32'(nxt_c), 32'(c));
        chk1("R8", "V", 32'(nxt_v), 32'(v));
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state inputs: AND of zeros gives zero, Z set (R7)
        apply(4'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R2: carry out and overflow corners
        apply(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd5, 32'hFFFF_FFFE, 32'h1, 1'b0, 1'b1, 1'b0, 1'b1);
        apply(4'd5, 32'h7FFF_FFFE, 32'h1, 1'b0, 1'b1, 1'b1, 1'b1);
        // R3: no-borrow carry, borrow when carry clear
        apply(4'd2, 32'd5, 32'd5, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd2, 32'd0, 32'd1, 1'b1, 1'b1, 1'b0, 1'b1);
        apply(4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd6, 32'd10, 32'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd6, 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        // R4: reverse operand order
        apply(4'd3, 32'd3, 32'd10, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd7, 32'd3, 32'd10, 1'b0, 1'b0, 1'b0, 1'b1);
        apply(4'd7, 32'd1, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1);
        // R5: compare/test with set_flags low
        apply(4'd10, 32'd7, 32'd9, 1'b0, 1'b0, 1'b0, 1'b0);
        apply(4'd11, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        apply(4'd8, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b1, 1'b0);
        apply(4'd9, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0);
        // R6/R8/R9: logic ops keep V, forward shifter carry, no flag write without request
        apply(4'd13, 32'hDEAD_BEEF, 32'h8000_0001, 1'b1, 1'b0, 1'b1, 1'b0);
        apply(4'd15, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        apply(4'd12, 32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b1, 1'b1, 1'b1);
        apply(4'd1, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0);
        // all opcodes against mixed operands
        for (int k = 0; k < 16; k++) begin
            apply(4'(k), 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
            apply(4'(k), 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0);
        end
        for (int k = 0; k < 3000; k++) begin
            apply(4'($urandom), $urandom, (k % 7 == 0) ? 32'h8000_0000 : $urandom,
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule